// File: doc/BRIEF.md
# Trapping Add/Subtract Unit with Exception PC Capture

This block performs 32-bit two's-complement addition and subtraction for an integer datapath and decides, per operation, whether a signed overflow must raise an exception. Subtraction reuses the adder: the second operand is inverted and a carry-in of one is applied. The sum is formed by a carry-select adder. The low half ripples normally. The high half is computed twice, once for each possible carry, and the low-half carry-out picks one of the two.

Each operation is presented with a valid strobe, an op select, a trap-enable flag and the program counter of the issuing instruction. When trap-enable is clear, an overflowing result simply wraps. When trap-enable is set and the signed result overflows, the unit raises a one-cycle exception request. In the same cycle it drives a fixed handler address as the redirect target and stores the faulting PC in an exception PC register. That register stays readable on a dedicated output until the next trapping overflow.

All outputs are registered. Results appear one clock after the operation is presented.

Top module: `trap_addsub`

## Requirements
- R1: With op_sub=0, one cycle after in_valid the output sum_out equals (opa + opb) mod 2^32.
- R2: With op_sub=1, one cycle after in_valid the output sum_out equals (opa - opb) mod 2^32.
- R3: For an add, ovf_out is 1 exactly when opa[31] equals opb[31] and the sum's bit 31 differs from opa[31].
- R4: For a subtract, ovf_out is 1 exactly when opa[31] differs from opb[31] and the difference's bit 31 differs from opa[31].
- R5: When trap_en=0, an overflow raises no exception: exc_req stays 0, epc_out is unchanged and sum_out holds the wrapped value.
- R6: When in_valid=1, trap_en=1 and the operation overflows, then one cycle later exc_req=1, redirect_pc equals the parameter HANDLER_ADDR (default 32'h8000_0180) and epc_out equals the pc_in given with that operation.
- R7: exc_req is high for exactly one cycle per trapping overflow, and redirect_pc is 0 in every cycle in which exc_req is 0.
- R8: A cycle with in_valid=0 leaves sum_out, ovf_out and epc_out unchanged and drives exc_req to 0, whatever the operand inputs are.
- R9: While rst is high at a clock edge, every output is cleared to 0.
- R10: epc_out changes only together with exc_req. A trapping operation that does not overflow leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| trap_en | input | 1 | 1 = overflow raises an exception |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| pc_in | input | 32 | PC of the issuing operation |
| sum_out | output | 32 | Registered result |
| ovf_out | output | 1 | Registered signed-overflow flag |
| exc_req | output | 1 | One-cycle exception request |
| redirect_pc | output | 32 | Handler address while exc_req is high, else 0 |
| epc_out | output | 32 | Stored exception PC |

## Verification
The directed cases target the sign boundaries. They add one to the largest positive value, add the most negative value to itself, subtract one from the most negative value and subtract the most negative value from zero. An overflow rule with swapped sign conditions, or one that ignores op_sub, would flag the wrong one of these cases. Other cases place a carry exactly at the half-word seam. A carry-select mux driven by the wrong carry would corrupt the upper half there while random operands mostly pass. Further cases give an overflowing operation with trap_en clear, an overflow with in_valid low, and a trap followed by further operations. These catch a design that traps on the non-trapping form, captures the PC of an idle cycle, or holds exc_req high too long.

// File: rtl/trap_addsub_pkg.sv
package trap_addsub_pkg;
  localparam int unsigned DATA_W = 32;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } alu_op_e;
endpackage

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum
);
  localparam int unsigned LO_W = WIDTH / 2;
  localparam int unsigned HI_W = WIDTH - LO_W;

  logic [LO_W:0]   lo_full;
  logic [HI_W-1:0] hi_cand [2];

  assign lo_full = {1'b0, x[LO_W-1:0]} + {1'b0, y[LO_W-1:0]} + {{LO_W{1'b0}}, cin};

  for (genvar c = 0; c < 2; c++) begin : g_hi
    localparam logic [HI_W-1:0] CARRY = HI_W'(c);
    assign hi_cand[c] = x[WIDTH-1:LO_W] + y[WIDTH-1:LO_W] + CARRY;
  end

  assign sum = {(lo_full[LO_W] ? hi_cand[1] : hi_cand[0]), lo_full[LO_W-1:0]};
endmodule

// File: rtl/ovf_detect.sv
module ovf_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y_eff,
  input  logic [WIDTH-1:0] sum,
  output logic             ovf
);
  localparam int unsigned MSB = WIDTH - 1;
  // Same-sign inputs to the adder combined with a sign flip of the result.
  assign ovf = (x[MSB] == y_eff[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int unsigned WIDTH = 32,
  parameter logic [WIDTH-1:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_trap,
  input  logic [WIDTH-1:0] pc_in,
  output logic             exc_req,
  output logic [WIDTH-1:0] redirect_pc,
  output logic [WIDTH-1:0] epc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req     <= 1'b0;
      redirect_pc <= '0;
      epc         <= '0;
    end else begin
      exc_req     <= take_trap;
      redirect_pc <= take_trap ? HANDLER_ADDR : '0;
      if (take_trap) epc <= pc_in;
    end
  end
endmodule

// File: rtl/trap_addsub.sv
module trap_addsub
  import trap_addsub_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  parameter logic [WIDTH-1:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic             trap_en,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] pc_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             ovf_out,
  output logic             exc_req,
  output logic [WIDTH-1:0] redirect_pc,
  output logic [WIDTH-1:0] epc_out
);
  alu_op_e         op;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum_c;
  logic             ovf_c;
  logic             take_trap;

  assign op    = alu_op_e'(op_sub);
  assign b_eff = (op == OP_SUB) ? ~opb : opb;

  csel_adder #(.WIDTH(WIDTH)) u_add (
    .x(opa), .y(b_eff), .cin(op == OP_SUB), .sum(sum_c)
  );

  ovf_detect #(.WIDTH(WIDTH)) u_ovf (
    .x(opa), .y_eff(b_eff), .sum(sum_c), .ovf(ovf_c)
  );

  assign take_trap = in_valid && trap_en && ovf_c;

  trap_ctrl #(.WIDTH(WIDTH), .HANDLER_ADDR(HANDLER_ADDR)) u_trap (
    .clk(clk), .rst(rst), .take_trap(take_trap), .pc_in(pc_in),
    .exc_req(exc_req), .redirect_pc(redirect_pc), .epc(epc_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out <= '0;
      ovf_out <= 1'b0;
    end else if (in_valid) begin
      sum_out <= sum_c;
      ovf_out <= ovf_c;
    end
  end
endmodule

// File: rtl/trap_addsub_chk.sv
module trap_addsub_chk #(
  parameter int unsigned WIDTH = 32,
  parameter logic [WIDTH-1:0] HANDLER_ADDR = 32'h8000_0180
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             op_sub,
  input logic             trap_en,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [WIDTH-1:0] pc_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             ovf_out,
  input logic             exc_req,
  input logic [WIDTH-1:0] redirect_pc,
  input logic [WIDTH-1:0] epc_out
);
  localparam int unsigned MSB = WIDTH - 1;
  logic past_ok;

  always_ff @(posedge clk) past_ok <= !rst;

  assert_sum_R1_R2: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(in_valid) |->
      sum_out == ($past(op_sub) ? $past(opa) - $past(opb) : $past(opa) + $past(opb)));

  assert_add_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(in_valid) && !$past(op_sub) |->
      ovf_out == (($past(opa[MSB]) == $past(opb[MSB])) && (sum_out[MSB] != $past(opa[MSB]))));

  assert_sub_ovf_R4: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(in_valid) && $past(op_sub) |->
      ovf_out == (($past(opa[MSB]) != $past(opb[MSB])) && (sum_out[MSB] != $past(opa[MSB]))));

  assert_no_trap_R5: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(trap_en) |-> !exc_req);

  assert_trap_epc_R6: assert property (@(posedge clk) disable iff (rst)
    past_ok && exc_req |-> ovf_out && epc_out == $past(pc_in) && redirect_pc == HANDLER_ADDR);

  assert_redirect_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !exc_req |-> redirect_pc == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(in_valid) |-> $stable(sum_out) && $stable(ovf_out) && !exc_req);

  assert_epc_stable_R10: assert property (@(posedge clk) disable iff (rst)
    past_ok && !exc_req |-> $stable(epc_out));
endmodule

bind trap_addsub trap_addsub_chk #(.WIDTH(WIDTH), .HANDLER_ADDR(HANDLER_ADDR)) u_chk (.*);

// File: tb/trap_addsub_tb.sv
module trap_addsub_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HANDLER = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst, in_valid, op_sub, trap_en;
  logic [31:0] opa, opb, pc_in;
  logic [31:0] sum_out, redirect_pc, epc_out;
  logic        ovf_out, exc_req;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] m_sum, m_epc;
  logic        m_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_addsub u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub), .trap_en(trap_en),
    .opa(opa), .opb(opb), .pc_in(pc_in), .sum_out(sum_out), .ovf_out(ovf_out),
    .exc_req(exc_req), .redirect_pc(redirect_pc), .epc_out(epc_out)
  );

  function automatic logic [31:0] exp_res(logic [31:0] a, logic [31:0] b, logic s);
    return s ? a - b : a + b;
  endfunction

  function automatic logic exp_ovf(logic [31:0] a, logic [31:0] b, logic s);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint r  = s ? sa - sb : sa + sb;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_op(logic [31:0] a, logic [31:0] b, logic s, logic t, logic [31:0] pc);
    logic o;
    @(negedge clk);
    in_valid = 1'b1; op_sub = s; trap_en = t; opa = a; opb = b; pc_in = pc;
    o = exp_ovf(a, b, s);
    m_sum = exp_res(a, b, s);
    m_ovf = o;
    if (t && o) m_epc = pc;
    @(negedge clk);
    check(s ? "R2 sum" : "R1 sum", sum_out, m_sum);
    check(s ? "R4 ovf" : "R3 ovf", {31'b0, ovf_out}, {31'b0, m_ovf});
    check(t ? "R6 exc_req" : "R5 exc_req", {31'b0, exc_req}, {31'b0, t && o});
    check("R7 redirect", redirect_pc, (t && o) ? HANDLER : 32'h0);
    check(t ? "R10 epc" : "R5 epc", epc_out, m_epc);
  endtask

  task automatic idle(logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b0; trap_en = 1'b1; op_sub = 1'b0; opa = a; opb = b; pc_in = $urandom;
    @(negedge clk);
    check("R8 sum held", sum_out, m_sum);
    check("R8 ovf held", {31'b0, ovf_out}, {31'b0, m_ovf});
    check("R8 exc_req", {31'b0, exc_req}, 32'h0);
    check("R7 redirect idle", redirect_pc, 32'h0);
    check("R8 epc held", epc_out, m_epc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0; trap_en = 1'b0;
    opa = 32'h7fff_ffff; opb = 32'h1; pc_in = 32'h1234;
    m_sum = 0; m_ovf = 0; m_epc = 0;
    in_valid = 1'b1; trap_en = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset clears all outputs even with a trapping overflow presented
    check("R9 sum", sum_out, 0);
    check("R9 ovf", {31'b0, ovf_out}, 0);
    check("R9 exc_req", {31'b0, exc_req}, 0);
    check("R9 redirect", redirect_pc, 0);
    check("R9 epc", epc_out, 0);
    rst = 1'b0; in_valid = 1'b0;

    do_op(32'd5, 32'd3, 1'b1, 1'b1, 32'h100);               // R2 plain
    do_op(32'h0000_ffff, 32'h0000_0001, 1'b0, 1'b1, 32'h104); // R1 carry at seam
    do_op(32'hffff_ffff, 32'h0000_0001, 1'b0, 1'b0, 32'h108); // R1 wrap, no ovf
    do_op(32'h7fff_ffff, 32'h1, 1'b0, 1'b0, 32'h10c);        // R5 ovf no trap
    do_op(32'h7fff_ffff, 32'h1, 1'b0, 1'b1, 32'h110);        // R6 trap
    do_op(32'h1, 32'h1, 1'b0, 1'b1, 32'h114);                // R7 pulse drops, R10
    do_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 32'h118); // R3 neg+neg
    do_op(32'h8000_0000, 32'h1, 1'b1, 1'b1, 32'h11c);        // R4 neg-pos
    do_op(32'h0, 32'h8000_0000, 1'b1, 1'b1, 32'h120);        // R4 pos-neg
    do_op(32'hffff_ffff, 32'h8000_0000, 1'b1, 1'b1, 32'h124); // R4 same sign
    do_op(32'h8000_0000, 32'h7fff_ffff, 1'b0, 1'b1, 32'h128); // R3 mixed sign
    idle(32'h7fff_ffff, 32'h1);                             // R8 idle with ovf operands
    do_op(32'h0001_0000, 32'h1, 1'b1, 1'b0, 32'h12c);       // R2 borrow at seam

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 5 == 0) begin a[30:0] = 31'h7fff_ffff; end
      do_op(a, b, 1'($urandom), 1'($urandom), $urandom);
      if (i % 17 == 0) idle($urandom, $urandom);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule